// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a clocked on-chip requester and an external asynchronous static RAM of 32K words by 16 bits. A requester offers one read or one write at a time through a valid/ready handshake. Each request carries a 15-bit word address, a 16-bit write word and a two-bit lane enable. The controller turns each accepted request into a timed sequence on the memory pins. The memory's chip enable is active high. Its output enable, write enable and the two byte selects are active low. The shared data bus is split into separate in, out and output-enable signals, and a pad ring outside the block merges them.

All memory timing is met by counting clock cycles, and parameters set the number of cycles. By default the controller runs at 100 MHz. A read holds output enable low for two cycles and captures the word at the end of the second. It then spends one idle cycle with every pin released, so that the memory's output driver can switch off. A write spends one setup cycle with address and selects stable. It then holds write enable low for two cycles and keeps its own data driver on for one more cycle after write enable rises. Read data comes back with a one-cycle strobe, and any lane that was not enabled returns zero.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and in every cycle in which the controller is idle, the memory chip enable is low, output enable, write enable and both byte selects are high, the data driver is off and `req_ready` is high.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low for RD_WAIT+TURN_IDLE cycles after a read is taken and for WR_SETUP+WR_PULSE+1 cycles after a write is taken.
- R3: For the RD_WAIT cycles that follow a taken read, the pins show chip enable high, output enable low, write enable high, the requested address and byte selects equal to the inverse of the lane enable. Lane enable bit 0 maps to the lower select (data bits 7:0) and bit 1 maps to the upper select (bits 15:8). The address does not change while chip enable stays high.
- R4: `rsp_valid` is high for exactly one cycle, RD_WAIT cycles after the edge that took the read. In that cycle `rsp_rdata` holds the bus word sampled at the end of the last wait cycle.
- R5: In `rsp_rdata`, every byte lane whose lane-enable bit was 0 reads as 0x00, even when the bus carries other values on those bits. With lane enable 0b00 the whole word is zero.
- R6: A taken write first holds write enable high for WR_SETUP cycles, with chip enable high, output enable high and the selects applied. It then holds write enable low for WR_PULSE cycles.
- R7: The data driver is on only while write enable is low and for one cycle after write enable rises, and while it is on it drives the write word.
- R8: A write changes only the memory lanes whose lane-enable bit is 1. A write with lane enable 0b00 leaves the word unchanged.
- R9: The controller's data driver and the memory's read driver are never on in the same cycle. After a read, output enable is high and the driver stays off for TURN_IDLE cycles before any new request is taken.
- R10: Output enable and write enable are never low together, and write enable is low only while chip enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 16 | Write word |
| req_lanes | input | 2 | Lane enable, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read word, disabled lanes zero |
| mem_addr | output | 15 | Memory address pins |
| mem_ce | output | 1 | Chip enable, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bsel_n | output | 2 | Byte selects, active low, bit 0 lower, bit 1 upper |
| mem_dq_o | output | 16 | Data to the bus |
| mem_dq_i | input | 16 | Data from the bus |
| mem_dq_oe | output | 1 | Controller drives the bus |

## Verification
The assertions check the local pin rules in every cycle. These cover the exclusion of the two enables, write enable only under chip enable, a quiet idle state, a stable address under chip enable, the driver hold after the write-enable rise, a single-cycle response and zeroed disabled lanes. Only the bench's scenarios can show the rest: the exact cycle counts of each phase against the handshake, the data that actually lands in a memory that follows the truth table, and the absence of bus contention with a real memory driver. That memory puts a non-zero pattern on undriven lanes, so a missing lane mask shows up in the returned data.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RD    = 3'd1,
      ST_TURN  = 3'd2,
      ST_WSET  = 3'd3,
      ST_WPUL  = 3'd4,
      ST_WHOLD = 3'd5
   } seq_state_t;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
   import sram_lane_pkg::*;
#(
   parameter int RD_WAIT   = 2,
   parameter int TURN_IDLE = 1,
   parameter int WR_SETUP  = 1,
   parameter int WR_PULSE  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_write,
   output logic ready,
   output logic take,
   output logic cap_fire,
   output logic ce,
   output logic oe_n,
   output logic we_n,
   output logic drv_en,
   output logic sel_on
);

   localparam int LONGEST = max2(max2(RD_WAIT, TURN_IDLE), max2(WR_SETUP, WR_PULSE));
   localparam int CW      = $clog2(LONGEST + 1);

   localparam logic [CW-1:0] RD_LOAD   = CW'(RD_WAIT - 1);
   localparam logic [CW-1:0] TURN_LOAD = CW'(TURN_IDLE - 1);
   localparam logic [CW-1:0] SET_LOAD  = CW'(WR_SETUP - 1);
   localparam logic [CW-1:0] PUL_LOAD  = CW'(WR_PULSE - 1);

   if (RD_WAIT < 1) begin : g_bad_rd
      $error("RD_WAIT must be at least 1");
   end
   if (TURN_IDLE < 1) begin : g_bad_turn
      $error("TURN_IDLE must be at least 1");
   end
   if (WR_SETUP < 1) begin : g_bad_set
      $error("WR_SETUP must be at least 1");
   end
   if (WR_PULSE < 2) begin : g_bad_pul
      $error("WR_PULSE must be at least 2");
   end

   seq_state_t    state_q;
   logic [CW-1:0] cnt_q;
   logic          cnt_zero;

   assign cnt_zero = (cnt_q == '0);
   assign ready    = (state_q == ST_IDLE);
   assign take     = ready & req_valid;
   assign cap_fire = (state_q == ST_RD) & cnt_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         ce      <= 1'b0;
         oe_n    <= 1'b1;
         we_n    <= 1'b1;
         drv_en  <= 1'b0;
         sel_on  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (take) begin
                  ce     <= 1'b1;
                  sel_on <= 1'b1;
                  if (req_write) begin
                     state_q <= ST_WSET;
                     cnt_q   <= SET_LOAD;
                  end else begin
                     state_q <= ST_RD;
                     cnt_q   <= RD_LOAD;
                     oe_n    <= 1'b0;
                  end
               end
            end
            ST_RD: begin
               if (cnt_zero) begin
                  state_q <= ST_TURN;
                  cnt_q   <= TURN_LOAD;
                  oe_n    <= 1'b1;
                  ce      <= 1'b0;
                  sel_on  <= 1'b0;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_TURN: begin
               if (cnt_zero) state_q <= ST_IDLE;
               else          cnt_q   <= cnt_q - 1'b1;
            end
            ST_WSET: begin
               if (cnt_zero) begin
                  state_q <= ST_WPUL;
                  cnt_q   <= PUL_LOAD;
                  we_n    <= 1'b0;
                  drv_en  <= 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_WPUL: begin
               if (cnt_zero) begin
                  state_q <= ST_WHOLD;
                  we_n    <= 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_WHOLD: begin
               state_q <= ST_IDLE;
               drv_en  <= 1'b0;
               ce      <= 1'b0;
               sel_on  <= 1'b0;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R10
   oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!oe_n && !we_n));

   // R10
   we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> ce);

   // R7
   drv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> drv_en);

   // R7
   drv_off_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en && we_n && $past(we_n)) |=> !drv_en);

   // R9
   drv_not_reading_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en |-> oe_n);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (!ce && oe_n && we_n && !drv_en && !sel_on));

endmodule

// File: rtl/sram_lane_path.sv
module sram_lane_path #(
   parameter int AW = 15,
   parameter int DW = 16,
   parameter int NL = DW / 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          sel_on,
   input  logic          ce,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic [NL-1:0] req_lanes,
   output logic [AW-1:0] mem_addr,
   output logic [NL-1:0] mem_bsel_n,
   output logic [DW-1:0] wdata_o,
   output logic [NL-1:0] lanes_o
);

   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;
   logic [NL-1:0] lanes_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         lanes_q <= '0;
      end else if (take) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         lanes_q <= req_lanes;
      end
   end

   assign mem_addr   = addr_q;
   assign mem_bsel_n = sel_on ? ~lanes_q : '1;
   assign wdata_o    = wdata_q;
   assign lanes_o    = lanes_q;

   // R3
   addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && $past(ce)) |-> $stable(mem_addr));

endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
   parameter int DW = 16,
   parameter int NL = DW / 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_fire,
   input  logic [NL-1:0] lanes,
   input  logic [DW-1:0] dq_i,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata
);

   logic [7:0] lane_q [NL];

   for (genvar i = 0; i < NL; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        lane_q[i] <= '0;
         else if (cap_fire) lane_q[i] <= lanes[i] ? dq_i[i*8 +: 8] : 8'h00;
      end
      assign rsp_rdata[i*8 +: 8] = lane_q[i];

      // R5
      off_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_valid && !lanes[i]) |-> (rsp_rdata[i*8 +: 8] == 8'h00));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsp_valid <= 1'b0;
      else        rsp_valid <= cap_fire;
   end

   // R4
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
   parameter int AW        = 15,
   parameter int DW        = 16,
   parameter int RD_WAIT   = 2,
   parameter int TURN_IDLE = 1,
   parameter int WR_SETUP  = 1,
   parameter int WR_PULSE  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_write,
   input  logic [AW-1:0]       req_addr,
   input  logic [DW-1:0]       req_wdata,
   input  logic [DW/8-1:0]     req_lanes,
   output logic                rsp_valid,
   output logic [DW-1:0]       rsp_rdata,
   output logic [AW-1:0]       mem_addr,
   output logic                mem_ce,
   output logic                mem_oe_n,
   output logic                mem_we_n,
   output logic [DW/8-1:0]     mem_bsel_n,
   output logic [DW-1:0]       mem_dq_o,
   input  logic [DW-1:0]       mem_dq_i,
   output logic                mem_dq_oe
);

   localparam int NL = DW / 8;

   if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
      $error("DW must be a non-zero multiple of 8");
   end
   if (AW < 1) begin : g_bad_aw
      $error("AW must be at least 1");
   end

   logic          take;
   logic          cap_fire;
   logic          sel_on;
   logic [NL-1:0] lanes_q;

   sram_lane_seq #(
      .RD_WAIT  (RD_WAIT),
      .TURN_IDLE(TURN_IDLE),
      .WR_SETUP (WR_SETUP),
      .WR_PULSE (WR_PULSE)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_write(req_write),
      .ready    (req_ready),
      .take     (take),
      .cap_fire (cap_fire),
      .ce       (mem_ce),
      .oe_n     (mem_oe_n),
      .we_n     (mem_we_n),
      .drv_en   (mem_dq_oe),
      .sel_on   (sel_on)
   );

   sram_lane_path #(
      .AW(AW),
      .DW(DW),
      .NL(NL)
   ) u_path (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .sel_on    (sel_on),
      .ce        (mem_ce),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_lanes (req_lanes),
      .mem_addr  (mem_addr),
      .mem_bsel_n(mem_bsel_n),
      .wdata_o   (mem_dq_o),
      .lanes_o   (lanes_q)
   );

   sram_lane_capture #(
      .DW(DW),
      .NL(NL)
   ) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_fire (cap_fire),
      .lanes    (lanes_q),
      .dq_i     (mem_dq_i),
      .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata)
   );

   // R2
   take_only_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid) |=> !req_ready);

endmodule

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;

   localparam int AW = 15;
   localparam int DW = 16;
   localparam int RDW = 2;
   localparam int TRN = 1;
   localparam int WST = 1;
   localparam int WPL = 2;
   localparam int RD_TOTAL = RDW + TRN;
   localparam int WR_TOTAL = WST + WPL + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0]    req_lanes = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_ce;
   logic          mem_oe_n;
   logic          mem_we_n;
   logic [1:0]    mem_bsel_n;
   logic [DW-1:0] mem_dq_o;
   logic [DW-1:0] mem_dq_i;
   logic          mem_dq_oe;

   always #4 clk = ~clk;

   sram_lane_ctrl #(
      .AW(AW), .DW(DW), .RD_WAIT(RDW), .TURN_IDLE(TRN),
      .WR_SETUP(WST), .WR_PULSE(WPL)
   ) u_sram_lane_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_lanes(req_lanes), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_ce(mem_ce), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_bsel_n(mem_bsel_n), .mem_dq_o(mem_dq_o),
      .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe)
   );

   int errs = 0;
   int checks = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h at %0t", rq, act, exp, $time);
      end
   endtask

   // ---------------- pin-level memory model ----------------
   logic [15:0] model_mem [int unsigned];
   logic [15:0] exp_mem   [int unsigned];

   function automatic logic [15:0] model_get(input logic [AW-1:0] a);
      if (model_mem.exists(int'(a))) return model_mem[int'(a)];
      return 16'h0000;
   endfunction

   function automatic logic [15:0] exp_get(input logic [AW-1:0] a);
      if (exp_mem.exists(int'(a))) return exp_mem[int'(a)];
      return 16'h0000;
   endfunction

   logic mem_reading;
   assign mem_reading = mem_ce && mem_we_n && !mem_oe_n;

   always @(*) begin
      logic [15:0] w;
      w = model_get(mem_addr);
      for (int i = 0; i < 2; i++) begin
         if (mem_dq_oe)                         mem_dq_i[i*8 +: 8] = mem_dq_o[i*8 +: 8];
         else if (mem_reading && !mem_bsel_n[i]) mem_dq_i[i*8 +: 8] = w[i*8 +: 8];
         else                                    mem_dq_i[i*8 +: 8] = 8'hA5;
      end
   end

   always @(posedge clk) begin
      if (rst_n && mem_ce && !mem_we_n) begin
         logic [15:0] w;
         w = model_get(mem_addr);
         for (int i = 0; i < 2; i++) begin
            if (!mem_bsel_n[i]) w[i*8 +: 8] = mem_dq_o[i*8 +: 8];
         end
         // R7: data must be driven whenever the memory is writing
         chk(mem_dq_oe, "R7 write without driver", {31'd0, mem_dq_oe}, 32'd1);
         model_mem[int'(mem_addr)] = w;
      end
   end

   // ---------------- behavioural reference of the handshake ----------------
   bit            active = 1'b0;
   bit            cur_wr = 1'b0;
   int            e = 0;
   logic [AW-1:0] cur_addr;
   logic [15:0]   cur_data;
   logic [1:0]    cur_lanes;
   logic [15:0]   exp_rd;
   int            acc_cnt = 0;

   always @(posedge clk) begin
      if (rst_n) begin
         bit acc;
         acc = req_valid && req_ready;
         if (active) begin
            e++;
            if (e >= (cur_wr ? WR_TOTAL : RD_TOTAL)) active = 1'b0;
         end
         if (acc) begin
            // R2: a take is only legal when the reference says idle
            chk(!active, "R2 take while busy", {31'd0, active}, 32'd0);
            active    = 1'b1;
            e         = 0;
            cur_wr    = req_write;
            cur_addr  = req_addr;
            cur_data  = req_wdata;
            cur_lanes = req_lanes;
            if (req_write) begin
               logic [15:0] w;
               w = exp_get(req_addr);
               for (int i = 0; i < 2; i++)
                  if (req_lanes[i]) w[i*8 +: 8] = req_wdata[i*8 +: 8];
               exp_mem[int'(req_addr)] = w;
            end else begin
               logic [15:0] w;
               w = exp_get(req_addr);
               for (int i = 0; i < 2; i++)
                  if (!req_lanes[i]) w[i*8 +: 8] = 8'h00;
               exp_rd = w;
            end
            acc_cnt++;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [4:0] pins;
         bit         exp_rsp;
         bit         mem_drv;
         chk(req_ready == !active, "R2 ready", {31'd0, req_ready}, {31'd0, !active});
         exp_rsp = active && !cur_wr && (e == RDW);
         chk(rsp_valid == exp_rsp, "R4 rsp_valid timing", {31'd0, rsp_valid}, {31'd0, exp_rsp});
         if (exp_rsp)
            chk(rsp_rdata == exp_rd, "R5 read data / lane zeroing", {16'd0, rsp_rdata}, {16'd0, exp_rd});
         pins = {mem_ce, mem_oe_n, mem_we_n, mem_bsel_n};
         if (!active) begin
            chk(pins == 5'b0_1_1_11 && !mem_dq_oe, "R1 idle pins",
                {26'd0, mem_dq_oe, pins}, {26'd0, 1'b0, 5'b0_1_1_11});
         end else if (!cur_wr) begin
            if (e < RDW) begin
               chk(pins == {1'b1, 1'b0, 1'b1, ~cur_lanes}, "R3 read pins",
                   {27'd0, pins}, {27'd0, 1'b1, 1'b0, 1'b1, ~cur_lanes});
               chk(mem_addr == cur_addr, "R3 read address", {17'd0, mem_addr}, {17'd0, cur_addr});
            end else begin
               chk(mem_oe_n && !mem_dq_oe, "R9 read turnaround",
                   {30'd0, mem_oe_n, mem_dq_oe}, {30'd0, 2'b10});
            end
         end else begin
            bit wl;
            bit dv;
            wl = (e >= WST) && (e < WST + WPL);
            dv = (e >= WST) && (e <= WST + WPL);
            chk(pins == {1'b1, 1'b1, !wl, ~cur_lanes}, "R6 write pins",
                {27'd0, pins}, {27'd0, 1'b1, 1'b1, !wl, ~cur_lanes});
            chk(mem_dq_oe == dv, "R7 driver window", {31'd0, mem_dq_oe}, {31'd0, dv});
            if (dv)
               chk(mem_dq_o == cur_data, "R7 driven word", {16'd0, mem_dq_o}, {16'd0, cur_data});
         end
         mem_drv = mem_reading && (mem_bsel_n != 2'b11);
         chk(!(mem_drv && mem_dq_oe), "R9 bus contention", {30'd0, mem_drv, mem_dq_oe}, 32'd0);
         chk(!(!mem_oe_n && !mem_we_n) && (mem_we_n || mem_ce), "R10 enable rules",
             {29'd0, mem_ce, mem_oe_n, mem_we_n}, 32'd0);
      end
   end

   // ---------------- stimulus ----------------
   task automatic issue(input bit wr, input logic [AW-1:0] a,
                        input logic [15:0] d, input logic [1:0] ln);
      int n;
      n = acc_cnt;
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      req_lanes = ln;
      while (acc_cnt == n) @(negedge clk);
   endtask

   task automatic go_idle(input int cycles);
      req_valid = 1'b0;
      repeat (cycles) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: outputs while reset is asserted
      chk(!mem_ce && mem_oe_n && mem_we_n && mem_bsel_n == 2'b11 && !mem_dq_oe && !rsp_valid,
          "R1 reset state", {27'd0, mem_ce, mem_oe_n, mem_we_n, mem_bsel_n}, {27'd0, 5'b0_1_1_11});
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready, "R1 ready after reset", {31'd0, req_ready}, 32'd1);

      // R6 R8: full write, then R3 R4 read back
      issue(1'b1, 15'h0010, 16'h1234, 2'b11);
      issue(1'b0, 15'h0010, 16'h0000, 2'b11);
      // R8: lower lane only, held valid across busy cycles (R2)
      issue(1'b1, 15'h0010, 16'hABCD, 2'b01);
      issue(1'b0, 15'h0010, 16'h0000, 2'b11);
      issue(1'b1, 15'h0010, 16'h5577, 2'b10);
      // R5: partial reads
      issue(1'b0, 15'h0010, 16'h0000, 2'b01);
      issue(1'b0, 15'h0010, 16'h0000, 2'b10);
      issue(1'b0, 15'h0010, 16'h0000, 2'b00);
      go_idle(3);
      // top address, and a write with no lanes enabled (R8)
      issue(1'b1, 15'h7FFF, 16'hFFFF, 2'b11);
      issue(1'b1, 15'h7FFF, 16'h0000, 2'b00);
      issue(1'b0, 15'h7FFF, 16'h0000, 2'b11);
      go_idle(2);
      // R9: read immediately followed by write
      issue(1'b0, 15'h0000, 16'h0000, 2'b11);
      issue(1'b1, 15'h0000, 16'h0F0F, 2'b11);
      issue(1'b0, 15'h0000, 16'h0000, 2'b11);
      go_idle(1);
      for (int k = 0; k < 80; k++) begin
         issue(1'($urandom_range(0, 1)), AW'($urandom_range(0, 7)),
               16'($urandom), 2'($urandom_range(0, 3)));
         if ($urandom_range(0, 3) == 0) go_idle(int'($urandom_range(1, 3)));
      end
      go_idle(10);
      // R8: memory contents written through the pins match the lane-masked reference
      foreach (exp_mem[a]) begin
         logic [15:0] got;
         got = model_get(AW'(a));
         chk(got == exp_mem[a], "R8 stored word", {16'd0, got}, {16'd0, exp_mem[a]});
      end
      finish_run();
   end

endmodule